// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline may advance. It compares the two source register numbers of the instruction sitting in decode against the destinations of the instructions one and two slots ahead. When a value cannot yet be delivered by forwarding, it freezes the program counter and the fetch/decode register, and it replaces the control word that decode passes to execute with zeros, so that a no-op travels down the pipe.

Conditional branches compare their operands and resolve in decode. A branch needs its operands one stage earlier than an ALU instruction does. A producer one slot ahead therefore costs one stall cycle, and a load costs two: the first cycle while the load is in execute and the second while it is in memory access. Once the operands are ready and the branch is taken, the block raises a kill signal that zeroes the instruction word being written into the fetch/decode register. This discards the one wrongly fetched instruction.

Each cycle is placed in exactly one hazard class, tested in this priority order. `HZ_LOAD_USE` is a load in execute that feeds decode. `HZ_BR_WAIT_EX` is a branch waiting on a producer in execute. `HZ_BR_WAIT_MEM` is a branch waiting on a load in memory access. `HZ_REDIRECT` is a taken branch with its operands ready. `HZ_CLEAR` covers everything else. The class is recomputed from the inputs each cycle, and a cycle moves into any class from any class directly. The pipeline registers outside the block carry the sequence: a held load-use instruction sees a bubble ahead of it on the next cycle. The class drives the outputs through a single decode table.

Top module: `hzc_unit`

## Requirements
- R1: When the execute-stage load flag is set, the execute destination is nonzero and it equals either decode source, the block stalls. A stall means `pc_en`=0, `fetch_reg_en`=0 and `ctl_bubble`=1. This holds whether or not decode holds a branch.
- R2: A load-use stall lasts one cycle. When execute then holds the bubble (both execute flags clear) and decode holds no branch, the block does not stall. This includes the case where the load has reached memory access.
- R3: `pc_en` and `fetch_reg_en` are equal in every cycle.
- R4: `ctl_bubble` is 1 exactly in the cycles where `pc_en` is 0.
- R5: A destination equal to register 0 never causes a stall, whatever the flags and sources.
- R6: When decode holds a branch and execute holds a non-load register writer whose nonzero destination equals either decode source, the block stalls. A non-branch decode instruction does not stall for that producer.
- R7: When decode holds a branch and memory access holds a load whose nonzero destination equals either decode source, the block stalls. A non-branch decode instruction and a non-load memory-stage instruction cause no stall.
- R8: When decode holds a taken branch and no stall applies, `fetch_kill`=1 and `pc_en`=1.
- R9: In a cycle that stalls, `fetch_kill` is 0 even if decode holds a taken branch.
- R10: The taken input has no effect when decode does not hold a branch: `fetch_kill` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, samples the embedded properties |
| rst_n | input | 1 | Active-low reset, disables the properties |
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| ex_writes | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_W | Execute-stage destination register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | REG_W | Memory-stage destination register |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| dec_br_taken | input | 1 | Branch comparison in decode is true |
| pc_en | output | 1 | Program counter may update |
| fetch_reg_en | output | 1 | Fetch/decode register may update |
| ctl_bubble | output | 1 | Zero the control word passed from decode to execute |
| fetch_kill | output | 1 | Zero the instruction word written into fetch/decode |

## Verification
The hardest case is the second stall cycle of a branch behind a load. The load has left execute, so only the memory-stage load flag and destination hold the pipe. Any slip in that path is hidden by the earlier stall in a directed test. The bench reaches it by sweeping every combination of flags and 2-bit register numbers, which includes memory-stage load matches with a clear execute stage. It then replays the two-cycle load-to-branch and load-to-use sequences as the surrounding pipeline would present them.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    typedef enum logic [2:0] {
        HZ_CLEAR,
        HZ_LOAD_USE,
        HZ_BR_WAIT_EX,
        HZ_BR_WAIT_MEM,
        HZ_REDIRECT
    } hz_kind_e;

    typedef struct packed {
        logic pc_en;
        logic fetch_reg_en;
        logic ctl_bubble;
        logic fetch_kill;
    } hz_drive_t;

endpackage

// File: rtl/hzc_dep_match.sv
module hzc_dep_match #(
    parameter int REG_W = 5
) (
    input  logic             en,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    output logic             hit
);
    localparam logic [REG_W-1:0] REG_ZERO = '0;

    // register 0 is hard-wired, so a write to it never produces a dependence
    assign hit = en && (dst != REG_ZERO) && ((dst == src_a) || (dst == src_b));
endmodule

// File: rtl/hzc_classify.sv
module hzc_classify
    import hzc_pkg::*;
(
    input  logic     ex_load_hit,
    input  logic     ex_any_hit,
    input  logic     mem_load_hit,
    input  logic     is_branch,
    input  logic     br_taken,
    output hz_kind_e kind
);
    // priority: operand waits first, redirect only once operands are ready
    always_comb begin
        if (ex_load_hit)
            kind = HZ_LOAD_USE;
        else if (is_branch && ex_any_hit)
            kind = HZ_BR_WAIT_EX;
        else if (is_branch && mem_load_hit)
            kind = HZ_BR_WAIT_MEM;
        else if (is_branch && br_taken)
            kind = HZ_REDIRECT;
        else
            kind = HZ_CLEAR;
    end
endmodule

// File: rtl/hzc_drive.sv
module hzc_drive
    import hzc_pkg::*;
(
    input  hz_kind_e  kind,
    output hz_drive_t drv
);
    always_comb begin
        drv = '{pc_en: 1'b1, fetch_reg_en: 1'b1, ctl_bubble: 1'b0, fetch_kill: 1'b0};
        unique case (kind)
            HZ_CLEAR: ;
            HZ_LOAD_USE,
            HZ_BR_WAIT_EX,
            HZ_BR_WAIT_MEM:
                drv = '{pc_en: 1'b0, fetch_reg_en: 1'b0, ctl_bubble: 1'b1, fetch_kill: 1'b0};
            HZ_REDIRECT:
                drv.fetch_kill = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hzc_unit.sv
module hzc_unit
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             ex_is_load,
    input  logic             ex_writes,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             dec_is_branch,
    input  logic             dec_br_taken,
    output logic             pc_en,
    output logic             fetch_reg_en,
    output logic             ctl_bubble,
    output logic             fetch_kill
);
    // slot 0: load in execute, slot 1: any writer in execute, slot 2: load in memory
    localparam int NUM_SLOTS = 3;
    localparam logic [REG_W-1:0] REG_ZERO = '0;

    logic [NUM_SLOTS-1:0] slot_en;
    logic [REG_W-1:0]     slot_dst [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_hit;
    hz_kind_e             kind;
    hz_drive_t            drv;

    assign slot_en     = {mem_is_load, ex_is_load | ex_writes, ex_is_load};
    assign slot_dst[0] = ex_dst;
    assign slot_dst[1] = ex_dst;
    assign slot_dst[2] = mem_dst;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            hzc_dep_match #(.REG_W(REG_W)) u_match (
                .en    (slot_en[g]),
                .dst   (slot_dst[g]),
                .src_a (dec_src_a),
                .src_b (dec_src_b),
                .hit   (slot_hit[g])
            );
        end
    endgenerate

    hzc_classify u_classify (
        .ex_load_hit  (slot_hit[0]),
        .ex_any_hit   (slot_hit[1]),
        .mem_load_hit (slot_hit[2]),
        .is_branch    (dec_is_branch),
        .br_taken     (dec_br_taken),
        .kind         (kind)
    );

    hzc_drive u_drive (
        .kind (kind),
        .drv  (drv)
    );

    assign pc_en        = drv.pc_en;
    assign fetch_reg_en = drv.fetch_reg_en;
    assign ctl_bubble   = drv.ctl_bubble;
    assign fetch_kill   = drv.fetch_kill;

    AST_LOAD_USE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != REG_ZERO && (ex_dst == dec_src_a || ex_dst == dec_src_b))
        |-> (!pc_en && !fetch_reg_en && ctl_bubble)); // R1

    AST_HOLD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en == fetch_reg_en); // R3

    AST_BUBBLE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bubble == !pc_en); // R4

    AST_ZERO_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == REG_ZERO && mem_dst == REG_ZERO) |-> pc_en); // R5

    AST_KILL_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kill |-> pc_en); // R9

    AST_KILL_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kill |-> (dec_is_branch && dec_br_taken)); // R10
endmodule

// File: tb/test_hzc_unit.sv
module test_hzc_unit;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0, mem_dst = '0;
    logic          ex_is_load = 1'b0, ex_writes = 1'b0, mem_is_load = 1'b0;
    logic          dec_is_branch = 1'b0, dec_br_taken = 1'b0;
    logic          pc_en, fetch_reg_en, ctl_bubble, fetch_kill;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    hzc_unit #(.REG_W(RW)) i_hzc_unit (
        .clk, .rst_n, .dec_src_a, .dec_src_b, .ex_is_load, .ex_writes, .ex_dst,
        .mem_is_load, .mem_dst, .dec_is_branch, .dec_br_taken,
        .pc_en, .fetch_reg_en, .ctl_bubble, .fetch_kill
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit dep(input bit en, input int d, input int a, input int b);
        return en && d != 0 && (d == a || d == b);
    endfunction

    task automatic drive(input int a, input int b, input bit el, input bit ew, input int ed,
                         input bit ml, input int md, input bit br, input bit tk);
        @(negedge clk);
        dec_src_a = a[RW-1:0]; dec_src_b = b[RW-1:0];
        ex_is_load = el; ex_writes = ew; ex_dst = ed[RW-1:0];
        mem_is_load = ml; mem_dst = md[RW-1:0];
        dec_is_branch = br; dec_br_taken = tk;
        #1;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // reset state: idle inputs, free-running pipe
        check("R3", "reset pc_en", pc_en, 1);
        check("R4", "reset ctl_bubble", ctl_bubble, 0);
        check("R8", "reset fetch_kill", fetch_kill, 0);
        rst_n = 1'b1;

        // exhaustive sweep of the small configuration
        for (int v = 0; v < 8192; v++) begin
            int a, b, ed, md;
            bit el, ew, ml, br, tk, lu, bw_ex, bw_mem, stall, kill;
            string tag;
            a  = v & 3;        b  = (v >> 2) & 3;
            ed = (v >> 4) & 3; md = (v >> 6) & 3;
            el = v[8]; ew = v[9]; ml = v[10]; br = v[11]; tk = v[12];
            drive(a, b, el, ew, ed, ml, md, br, tk);
            lu     = dep(el, ed, a, b);
            bw_ex  = br && dep(el | ew, ed, a, b);
            bw_mem = br && dep(ml, md, a, b);
            stall  = lu || bw_ex || bw_mem;
            kill   = br && tk && !stall;
            if (ed == 0 && md == 0)     tag = "R5";
            else if (stall && br && tk) tag = "R9";
            else if (lu)                tag = "R1";
            else if (bw_ex)             tag = "R6";
            else if (bw_mem)            tag = "R7";
            else if (kill)              tag = "R8";
            else if (!br && tk)         tag = "R10";
            else                        tag = "R2";
            check(tag, $sformatf("pc_en v=%0d", v), pc_en, !stall);
            check(tag, $sformatf("fetch_kill v=%0d", v), fetch_kill, kill);
            check("R3", $sformatf("fetch_reg_en v=%0d", v), fetch_reg_en, pc_en);
            check("R4", $sformatf("ctl_bubble v=%0d", v), ctl_bubble, !pc_en);
        end

        // load then dependent ALU op: one stall, then bubble ahead releases it
        drive(1, 2, 1, 1, 2, 0, 0, 0, 0);
        check("R1", "load-use hold", pc_en, 0);
        drive(1, 2, 0, 0, 0, 1, 2, 0, 0);
        check("R2", "released after one cycle", pc_en, 1);

        // load then branch: two stalls, then redirect
        drive(3, 1, 1, 1, 3, 0, 0, 1, 1);
        check("R7", "branch behind load, first", pc_en, 0);
        check("R9", "no kill while held", fetch_kill, 0);
        drive(3, 1, 0, 0, 0, 1, 3, 1, 1);
        check("R7", "branch behind load, second", pc_en, 0);
        drive(3, 1, 0, 0, 0, 0, 0, 1, 1);
        check("R8", "kill after wait", fetch_kill, 1);
        check("R8", "pc advances on kill", pc_en, 1);

        // ALU producer then branch: one stall only
        drive(2, 0, 0, 1, 2, 0, 0, 1, 0);
        check("R6", "branch behind ALU op", pc_en, 0);
        drive(2, 0, 0, 0, 0, 0, 2, 1, 0);
        check("R6", "non-load in memory stage frees branch", pc_en, 1);

        // register 0 destination with every flag set
        drive(0, 0, 1, 1, 0, 1, 0, 1, 0);
        check("R5", "x0 producer", pc_en, 1);

        // taken without a branch
        drive(1, 1, 0, 0, 0, 0, 0, 0, 1);
        check("R10", "taken ignored", fetch_kill, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule